// File: doc/BRIEF.md
# Multiplexed Bus Address Demultiplexer

This block sits beside a processor whose local bus carries address, status and data on the same wires at different times in each bus cycle. It watches the address-strobe input and takes a snapshot of the 20-bit address and the active-low upper-byte-enable pin at the trailing edge of that strobe. It holds the snapshot until the next bus cycle starts, so downstream logic sees a plain, stable address bus.

The status bits that follow the address on the four top address wires and on the upper-byte-enable pin are valid only after the strobe has dropped. The block takes them from the first clock in which the strobe is low. From them it decodes which segment formed the address, the interrupt-enable reflection and the spare bit. It also raises a fault flag when the bit that must always read zero reads one. Byte-lane enables follow from address parity and the upper-byte-enable pin: even bytes use the low lane and odd bytes use the high lane.

The strobe and all bus wires are sampled on the rising edge of `clk`. A falling edge of the strobe is detected as one clock with the strobe high followed by a clock with it low.

Top module: `adl_demux_latch`

## Requirements
- R1: After reset, `addr_o` is 0, `bhe_n_o` is 1, `seg_o` is 0, all flags are 0, both lane enables are 0, `word_o` is 0 and `cap_o` is 0.
- R2: When `ale_i` is sampled high and then low on the next clock, `addr_o` takes {`a_hi_i`,`ad_i`} and `bhe_n_o` takes `bhe_s7_i` as they were in the last clock with `ale_i` high. Both are visible after the clock edge that samples `ale_i` low.
- R3: Between trailing edges, the latched address, status and flags do not change, whatever the bus or `ale_i` does.
- R4: The status is taken from the bus in the clock that samples `ale_i` low. S3 is `a_hi_i[0]`, S4 is `a_hi_i[1]`, S5 is `a_hi_i[2]`, S6 is `a_hi_i[3]` and S7 is `bhe_s7_i`. It appears at the same time as the address.
- R5: `seg_o` equals {S4,S3}: 00 is extra segment, 01 is stack, 10 is code or none, 11 is data.
- R6: `ie_o` equals the captured S5, and `spare_o` equals the captured S7.
- R7: Once an address has been captured, `lane_lo_o` is 1 when address bit 0 is 0, and `lane_hi_o` is 1 when `bhe_n_o` is 0. Before the first capture both are 0.
- R8: `word_o` is 1 exactly when both lane enables are 1.
- R9: `s6_err_o` is 1 when the captured S6 is 1.
- R10: `io_err_o` is 1 when `io_i` was high in the last clock with `ale_i` high and the latched address bits 19..16 are not all zero.
- R11: `cap_o` is 1 for exactly one clock, the clock in which a new capture appears on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ale_i | input | 1 | Address strobe; capture happens on its trailing edge |
| ad_i | input | 16 | Low address / data wires |
| a_hi_i | input | 4 | Address bits 19..16, then status S6..S3 |
| bhe_s7_i | input | 1 | Active-low upper-byte enable, then status S7 |
| io_i | input | 1 | High during the address phase of an I/O cycle |
| addr_o | output | 20 | Latched address |
| bhe_n_o | output | 1 | Latched upper-byte enable (active low) |
| seg_o | output | 2 | Decoded segment code |
| ie_o | output | 1 | Interrupt-enable reflection (S5) |
| spare_o | output | 1 | Spare status bit (S7) |
| s6_err_o | output | 1 | Captured S6 was 1 |
| io_err_o | output | 1 | I/O cycle with a nonzero upper address |
| lane_lo_o | output | 1 | Low byte lane enable |
| lane_hi_o | output | 1 | High byte lane enable |
| word_o | output | 1 | Both lanes enabled |
| cap_o | output | 1 | One-clock pulse when a new capture appears |

## Verification
A vector table drives bus cycles with even and odd addresses, each combined with the upper-byte enable active and inactive. This separates byte-low, byte-high and word transfers, and catches any lane swapped with the other. The status patterns cover all four segment codes and both values of S5, S6 and S7. Because the status values differ from the address bits sharing the same wires, a capture taken at the wrong phase shows up as a mismatch. Directed tests hold the strobe high for several clocks with a changing address, to show the last value before the trailing edge wins. They also toggle the bus while the strobe stays low, to show nothing moves. Further cases cover I/O cycles with zero and nonzero upper bits, and the single-clock width of the capture pulse.

// File: rtl/adl_pkg.sv
package adl_pkg;

  typedef enum logic [1:0] {
    SEG_EXTRA = 2'b00,
    SEG_STACK = 2'b01,
    SEG_CODE  = 2'b10,
    SEG_DATA  = 2'b11
  } seg_e;

  typedef struct packed {
    logic s7;
    logic s6;
    logic s5;
    seg_e seg;
  } stat_t;

  localparam stat_t STAT_RESET = '{s7: 1'b0, s6: 1'b0, s5: 1'b0, seg: SEG_EXTRA};

  // Unpack the four shared upper wires and the byte-enable wire into status.
  function automatic stat_t unpack_status(input logic [3:0] hi, input logic s7_pin);
    stat_t st;
    st.seg = seg_e'({hi[1], hi[0]});
    st.s5  = hi[2];
    st.s6  = hi[3];
    st.s7  = s7_pin;
    return st;
  endfunction

  // Lane enables: bit 0 is low lane, bit 1 is high lane.
  function automatic logic [1:0] lane_select(input logic a0, input logic bhe_n, input logic valid);
    return valid ? {~bhe_n, ~a0} : 2'b00;
  endfunction

  function automatic logic upper_nonzero(input logic [3:0] hi);
    return |hi;
  endfunction

endpackage

// File: rtl/adl_edge_det.sv
module adl_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic ale_i,
  output logic fall_o,
  output logic pulse_o
);
  logic ale_q;
  logic pulse_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ale_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      ale_q   <= ale_i;
      pulse_q <= fall_o;
    end
  end

  assign fall_o  = ale_q & ~ale_i;
  assign pulse_o = pulse_q;
endmodule

// File: rtl/adl_addr_cap.sv
module adl_addr_cap #(
  parameter int ADDR_W = 20,
  parameter int LO_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ale_i,
  input  logic              fall_i,
  input  logic [LO_W-1:0]   ad_i,
  input  logic [ADDR_W-LO_W-1:0] a_hi_i,
  input  logic              bhe_n_i,
  input  logic              io_i,
  output logic [ADDR_W-1:0] stage_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              bhe_n_o,
  output logic              io_o,
  output logic              valid_o
);
  logic [ADDR_W-1:0] stage_q;
  logic              stage_bhe_q;
  logic              stage_io_q;

  // Staging follows the bus while the strobe is high.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q     <= '0;
      stage_bhe_q <= 1'b1;
      stage_io_q  <= 1'b0;
    end else if (ale_i) begin
      stage_q     <= {a_hi_i, ad_i};
      stage_bhe_q <= bhe_n_i;
      stage_io_q  <= io_i;
    end
  end

  // Transfer to the held register on the trailing edge.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_o  <= '0;
      bhe_n_o <= 1'b1;
      io_o    <= 1'b0;
      valid_o <= 1'b0;
    end else if (fall_i) begin
      addr_o  <= stage_q;
      bhe_n_o <= stage_bhe_q;
      io_o    <= stage_io_q;
      valid_o <= 1'b1;
    end
  end

  assign stage_o = stage_q;
endmodule

// File: rtl/adl_stat_cap.sv
module adl_stat_cap
  import adl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fall_i,
  input  logic [3:0] hi_i,
  input  logic       s7_i,
  output stat_t      stat_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) stat_o <= STAT_RESET;
    else if (fall_i) stat_o <= unpack_status(hi_i, s7_i);
  end
endmodule

// File: rtl/adl_demux_latch.sv
module adl_demux_latch
  import adl_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int LO_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ale_i,
  input  logic [LO_W-1:0]   ad_i,
  input  logic [ADDR_W-LO_W-1:0] a_hi_i,
  input  logic              bhe_s7_i,
  input  logic              io_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              bhe_n_o,
  output logic [1:0]        seg_o,
  output logic              ie_o,
  output logic              spare_o,
  output logic              s6_err_o,
  output logic              io_err_o,
  output logic              lane_lo_o,
  output logic              lane_hi_o,
  output logic              word_o,
  output logic              cap_o
);
  localparam int HI_W = ADDR_W - LO_W;

  logic              fall_w;
  logic              valid_w;
  logic              io_w;
  logic [ADDR_W-1:0] stage_w;
  stat_t             stat_w;
  logic [1:0]        lanes_w;

  adl_edge_det u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .ale_i   (ale_i),
    .fall_o  (fall_w),
    .pulse_o (cap_o)
  );

  adl_addr_cap #(.ADDR_W(ADDR_W), .LO_W(LO_W)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .ale_i   (ale_i),
    .fall_i  (fall_w),
    .ad_i    (ad_i),
    .a_hi_i  (a_hi_i),
    .bhe_n_i (bhe_s7_i),
    .io_i    (io_i),
    .stage_o (stage_w),
    .addr_o  (addr_o),
    .bhe_n_o (bhe_n_o),
    .io_o    (io_w),
    .valid_o (valid_w)
  );

  adl_stat_cap u_stat (
    .clk    (clk),
    .rst_n  (rst_n),
    .fall_i (fall_w),
    .hi_i   (a_hi_i[3:0]),
    .s7_i   (bhe_s7_i),
    .stat_o (stat_w)
  );

  assign seg_o    = stat_w.seg;
  assign ie_o     = stat_w.s5;
  assign spare_o  = stat_w.s7;
  assign s6_err_o = stat_w.s6;

  assign lanes_w   = lane_select(addr_o[0], bhe_n_o, valid_w);
  assign lane_lo_o = lanes_w[0];
  assign lane_hi_o = lanes_w[1];
  assign word_o    = lanes_w[0] & lanes_w[1];

  assign io_err_o = io_w & upper_nonzero(addr_o[ADDR_W-1 -: 4]);

  logic unused_w;
  assign unused_w = ^{a_hi_i[HI_W-1:0]};
endmodule

// File: rtl/adl_demux_latch_chk.sv
module adl_demux_latch_chk #(
  parameter int ADDR_W = 20,
  parameter int LO_W   = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fall_w,
  input logic [ADDR_W-1:0] stage_w,
  input logic [ADDR_W-LO_W-1:0] a_hi_i,
  input logic              bhe_s7_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              ie_o,
  input logic              s6_err_o,
  input logic              io_err_o,
  input logic              lane_lo_o,
  input logic              lane_hi_o,
  input logic              word_o,
  input logic              cap_o
);
  // R2
  addr_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_w |=> addr_o == $past(stage_w));
  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_w |=> $stable(addr_o));
  // R6
  ie_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_w |=> ie_o == $past(a_hi_i[2]));
  // R9
  s6_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_w |=> s6_err_o == $past(a_hi_i[3]));
  // R7
  lane_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lane_lo_o |-> !addr_o[0]);
  // R8
  word_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_o |-> (lane_lo_o && lane_hi_o));
  // R10
  io_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_err_o |-> (addr_o[ADDR_W-1 -: 4] != 4'd0));
  // R11
  cap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_w |=> cap_o);
  // R11
  cap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_w |=> !cap_o);

  logic unused_c;
  assign unused_c = bhe_s7_i;
endmodule

bind adl_demux_latch adl_demux_latch_chk #(.ADDR_W(ADDR_W), .LO_W(LO_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .fall_w    (fall_w),
  .stage_w   (stage_w),
  .a_hi_i    (a_hi_i),
  .bhe_s7_i  (bhe_s7_i),
  .addr_o    (addr_o),
  .ie_o      (ie_o),
  .s6_err_o  (s6_err_o),
  .io_err_o  (io_err_o),
  .lane_lo_o (lane_lo_o),
  .lane_hi_o (lane_hi_o),
  .word_o    (word_o),
  .cap_o     (cap_o)
);

// File: tb/adl_demux_latch_tb_top.sv
module adl_demux_latch_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ale_i = 1'b0;
  logic [15:0] ad_i = '0;
  logic [3:0]  a_hi_i = '0;
  logic        bhe_s7_i = 1'b1;
  logic        io_i = 1'b0;
  logic [19:0] addr_o;
  logic        bhe_n_o;
  logic [1:0]  seg_o;
  logic        ie_o, spare_o, s6_err_o, io_err_o;
  logic        lane_lo_o, lane_hi_o, word_o, cap_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  adl_demux_latch dut_i (
    .clk(clk), .rst_n(rst_n), .ale_i(ale_i), .ad_i(ad_i), .a_hi_i(a_hi_i),
    .bhe_s7_i(bhe_s7_i), .io_i(io_i), .addr_o(addr_o), .bhe_n_o(bhe_n_o),
    .seg_o(seg_o), .ie_o(ie_o), .spare_o(spare_o), .s6_err_o(s6_err_o),
    .io_err_o(io_err_o), .lane_lo_o(lane_lo_o), .lane_hi_o(lane_hi_o),
    .word_o(word_o), .cap_o(cap_o)
  );

  // Vector: [26] io, [25:6] address, [5] bhe_n, [4:0] {S7,S6,S5,S4,S3}
  localparam int NV = 8;
  localparam logic [26:0] VEC [NV] = '{
    {1'b0, 20'h12344, 1'b0, 5'b00000},
    {1'b0, 20'hA5A51, 1'b0, 5'b00001},
    {1'b0, 20'h0F0F2, 1'b1, 5'b00110},
    {1'b0, 20'hFFFF3, 1'b1, 5'b10011},
    {1'b1, 20'h003F8, 1'b0, 5'b00101},
    {1'b1, 20'h5000B, 1'b0, 5'b01010},
    {1'b0, 20'hC3C3C, 1'b1, 5'b11111},
    {1'b1, 20'h00001, 1'b1, 5'b10000}
  };

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Drive one bus cycle; returns after the capture is visible (sample point).
  task automatic bus_cycle(input logic io, input logic [19:0] a, input logic bn, input logic [4:0] st);
    @(negedge clk);
    ale_i = 1'b1; ad_i = a[15:0]; a_hi_i = a[19:16]; bhe_s7_i = bn; io_i = io;
    @(negedge clk);
    ale_i = 1'b0; ad_i = ~a[15:0]; a_hi_i = st[3:0]; bhe_s7_i = st[4]; io_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic expect_all(input logic io, input logic [19:0] a, input logic bn, input logic [4:0] st);
    logic exp_lo, exp_hi;
    exp_lo = (a % 2) == 0;
    exp_hi = (bn == 1'b0);
    check("R2", "addr", addr_o, a);
    check("R2", "bhe", bhe_n_o, bn);
    check("R4/R5", "seg", seg_o, {st[1], st[0]});
    check("R6", "ie", ie_o, st[2]);
    check("R6", "spare", spare_o, st[4]);
    check("R9", "s6err", s6_err_o, st[3]);
    check("R10", "ioerr", io_err_o, io && (a >= 20'h10000));
    check("R7", "lanes", {lane_hi_o, lane_lo_o}, {exp_hi, exp_lo});
    check("R8", "word", word_o, exp_lo && exp_hi);
    check("R11", "cap", cap_o, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "addr", addr_o, 20'h0);
    check("R1", "bhe", bhe_n_o, 1'b1);
    check("R1", "flags", {seg_o, ie_o, spare_o, s6_err_o, io_err_o}, 6'b0);
    check("R1", "lanes", {lane_hi_o, lane_lo_o, word_o, cap_o}, 4'b0);

    for (int i = 0; i < NV; i++) begin
      bus_cycle(VEC[i][26], VEC[i][25:6], VEC[i][5], VEC[i][4:0]);
      expect_all(VEC[i][26], VEC[i][25:6], VEC[i][5], VEC[i][4:0]);
    end

    // R11: pulse lasts one clock
    @(negedge clk);
    check("R11", "cap low", cap_o, 1'b0);

    // R3: bus churn with strobe low changes nothing
    for (int k = 0; k < 5; k++) begin
      ad_i = 16'h1111 * k[15:0]; a_hi_i = k[3:0] ^ 4'hA; bhe_s7_i = k[0];
      @(negedge clk);
    end
    check("R3", "addr held", addr_o, 20'h00001);
    check("R3", "seg held", {seg_o, spare_o, s6_err_o}, {2'b00, 1'b1, 1'b0});

    // R2: strobe high several clocks, last value wins
    @(negedge clk);
    ale_i = 1'b1; ad_i = 16'h1000; a_hi_i = 4'h1; bhe_s7_i = 1'b1;
    @(negedge clk);
    ad_i = 16'h2000; a_hi_i = 4'h2;
    @(negedge clk);
    check("R3", "hold during strobe", addr_o, 20'h00001);
    ad_i = 16'h3456; a_hi_i = 4'h7; bhe_s7_i = 1'b0;
    @(negedge clk);
    ale_i = 1'b0; a_hi_i = 4'b0011; bhe_s7_i = 1'b0;
    @(negedge clk);
    check("R2", "last before edge", addr_o, 20'h73456);
    check("R5", "data seg", seg_o, 2'b11);
    check("R8", "word even+bhe", word_o, 1'b1);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule